// File: doc/BRIEF.md
# Event Timer Register Front End with Main Counter

This block is the register front end of a multi-channel event timer. It decodes a 1 KiB register window, answers 32-bit and 64-bit reads and writes, and holds four global registers: a read-only capability word, a two-bit global configuration, a per-channel interrupt status register with write-one-to-clear semantics, and a 64-bit main counter. The comparator channels live elsewhere. Accesses that fall inside a channel's slot are forwarded to them as a channel index, a register code, a lane-aligned write data word and a byte-lane bit mask. The channel's read data is returned through the same path.

The main counter advances by one on each clock on which the tick-enable input is high, but only while the global enable bit is set. Clearing the enable freezes the count. While the counter is halted, software may preload it through either 32-bit half. Setting the enable again resumes counting from the held value.

The bus is a single-cycle strobe interface. Writes take effect at the clock edge that samples them. Read data is combinational from the current state while the access strobe is high.

Top module: `evt_timer_regs`

## Requirements
- R1: Global registers decode by byte offset: capability at 0x000, configuration at 0x010, status at 0x020 and counter at 0x0F0. Any other offset below 0x100 (for example 0x018) reads as zero and ignores writes.
- R2: `bus_addr[2]` selects the upper 32-bit half. A read with bit 2 set returns bits 63:32 of the register in `bus_rdata[31:0]`, with the upper 32 bits of `bus_rdata` zero. A write with bit 2 set changes only bits 63:32. A 4-byte write with bit 2 clear changes only bits 31:0. An 8-byte write with bit 2 clear changes all 64 bits.
- R3: The capability word is read-only and has the following fields:
  - bits 7:0 hold 1;
  - bits 12:8 hold NCH-1;
  - bit 13 is 1;
  - bit 15 is 1;
  - bits 31:16 hold VENDOR;
  - bits 63:32 hold PERIOD_FS.
  With the defaults NCH=5, VENDOR=0xA5C3 and PERIOD_FS=10,000,000, the word is 0x00989680_A5C3A401.
- R4: In the configuration register, only bit 0 (global enable, driven on `glb_enable`) and bit 1 (legacy routing, driven on `legacy_route`) are writable. All other bits read as zero.
- R5: A high bit of `sts_set[i]` at a clock edge sets status bit i. A write to the status register clears each bit whose written value is 1 and leaves bits written 0 unchanged. A set and a clear of the same bit in one cycle leaves the bit set.
- R6: While the global enable is 1, the counter increments by one at each clock edge at which `tick_en` is 1, and reads return the live value.
- R7: While the global enable is 0, the counter holds its value regardless of `tick_en` and accepts writes. On re-enable it continues from the held value.
- R8: A counter write while the global enable is 1 is ignored.
- R9: An access to byte offset 0x100 + 0x20*n + 8*r, with n < NCH and r in {0,1,2}, is forwarded to the channel interface:
  - `ch_sel` carries n and `ch_reg` carries r;
  - `ch_wr` is high for writes;
  - `ch_wdata` carries the write data shifted into the addressed half;
  - `ch_wmask` marks the bits being written;
  - reads return `ch_rdata`.
- R10: A channel index of NCH or above, or a channel register code r=3, reads as zero and raises no `ch_wr`.
- R11: Reset clears the configuration, the status register and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | 8 | Byte address bits 9:2 within the window |
| bus_wdata | input | 64 | Write data, least significant lane first |
| bus_rdata | output | 64 | Read data, zero when no read is active |
| tick_en | input | 1 | Counter tick strobe |
| sts_set | input | NCH | Per-channel status set pulses |
| ch_rdata | input | 64 | Read data from the addressed channel register |
| ch_sel | output | 5 | Addressed channel index |
| ch_reg | output | 2 | Channel register code (0 config, 1 comparator, 2 route) |
| ch_wr | output | 1 | Channel write strobe |
| ch_wdata | output | 64 | Lane-aligned channel write data |
| ch_wmask | output | 64 | Bits of the channel register being written |
| glb_enable | output | 1 | Global enable bit |
| legacy_route | output | 1 | Legacy routing bit |

## Verification
A wrong write mask or a wrong half select shows up on the next read of the same register as a value with the untouched half altered. That error appears one cycle after the faulty write. A counter that ticks while disabled, or that accepts a write while enabled, leaves a count that differs from the bench's own running total at the next counter read. That read comes a few cycles later. Decode errors appear immediately, within the access cycle: a strobe on `ch_wr`, a wrong `ch_sel` or `ch_reg`, or nonzero read data at an offset that must read as zero.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CAP,
    TGT_CFG,
    TGT_STS,
    TGT_CNT,
    TGT_CH
  } tgt_e;

  // Bits of a 64-bit register touched by a write
  function automatic logic [63:0] lane_mask(input logic hi, input logic wide);
    if (hi)
      return 64'hFFFF_FFFF_0000_0000;
    else if (wide)
      return 64'hFFFF_FFFF_FFFF_FFFF;
    else
      return 64'h0000_0000_FFFF_FFFF;
  endfunction

  function automatic logic [63:0] lane_data(input logic hi, input logic [63:0] d);
    return hi ? {d[31:0], 32'h0} : d;
  endfunction

  function automatic logic [63:0] merge(
    input logic [63:0] old_v,
    input logic [63:0] new_v,
    input logic [63:0] mask
  );
    return (new_v & mask) | (old_v & ~mask);
  endfunction

  function automatic logic [63:0] cap_word(
    input int unsigned nch,
    input logic [15:0] vendor,
    input logic [31:0] period
  );
    logic [63:0] c;
    c        = '0;
    c[7:0]   = 8'd1;
    c[12:8]  = 5'(nch - 1);
    c[13]    = 1'b1;
    c[15]    = 1'b1;
    c[31:16] = vendor;
    c[63:32] = period;
    return c;
  endfunction
endpackage

// File: rtl/evt_decode.sv
module evt_decode import evt_pkg::*; #(
  parameter int unsigned NCH = 5
) (
  input  logic [9:2] addr,
  output tgt_e       tgt,
  output logic [4:0] ch_idx,
  output logic [1:0] ch_reg,
  output logic       hi
);
  logic       in_global;
  logic [4:0] slot;

  assign in_global = (addr[9:8] == 2'b00);
  assign slot      = addr[9:5] - 5'd8;
  assign ch_idx    = slot;
  assign ch_reg    = addr[4:3];
  assign hi        = addr[2];

  always_comb begin
    tgt = TGT_NONE;
    if (in_global) begin
      unique case (addr[7:3])
        5'd0:    tgt = TGT_CAP;
        5'd2:    tgt = TGT_CFG;
        5'd4:    tgt = TGT_STS;
        5'd30:   tgt = TGT_CNT;
        default: tgt = TGT_NONE;
      endcase
    end else if ((32'(slot) < NCH) && (addr[4:3] != 2'b11)) begin
      tgt = TGT_CH;
    end
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt
);
  logic step, load;

  assign step = en && tick;
  assign load = !en && wr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (step)
      cnt <= cnt + 1'b1;
    else if (load)
      cnt <= (wdata & wmask) | (cnt & ~wmask);
  end

  // R6: an enabled tick adds one
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) + 1'b1);

  // R7: held while disabled without a write
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr) |=> $stable(cnt));

  // R8: a write while enabled changes nothing beyond ticking
  p_busy_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int unsigned NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] sts
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sts <= '0;
    else
      sts <= (sts & ~clr) | set;
  end

  // R5: cleared bits drop unless set in the same cycle
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts & $past(clr & ~set)) == '0);

  // R5: set bits always land
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts & $past(set)) == $past(set));

  // R5: untouched bits keep their value
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts ^ $past(sts)) & ~$past(set | clr)) == '0);
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs import evt_pkg::*; #(
  parameter int unsigned NCH       = 5,
  parameter logic [15:0] VENDOR    = 16'hA5C3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic           bus_wide,
  input  logic [9:2]     bus_addr,
  input  logic [63:0]    bus_wdata,
  output logic [63:0]    bus_rdata,
  input  logic           tick_en,
  input  logic [NCH-1:0] sts_set,
  input  logic [63:0]    ch_rdata,
  output logic [4:0]     ch_sel,
  output logic [1:0]     ch_reg,
  output logic           ch_wr,
  output logic [63:0]    ch_wdata,
  output logic [63:0]    ch_wmask,
  output logic           glb_enable,
  output logic           legacy_route
);
  localparam logic [63:0] CAP     = cap_word(NCH, VENDOR, PERIOD_FS);
  localparam logic [63:0] CFG_WR  = 64'h3;

  initial begin
    if (NCH < 3 || NCH > 32)
      $error("NCH must lie between 3 and 32");
  end

  tgt_e        tgt;
  logic        hi;
  logic [63:0] wmask, wdata_al, full_rd;
  logic        wr_any, wr_cfg, wr_sts, wr_cnt;
  logic [1:0]  cfg_q;
  logic [63:0] cnt;
  logic [NCH-1:0] sts, sts_clr;

  evt_decode #(.NCH(NCH)) u_dec (
    .addr  (bus_addr),
    .tgt   (tgt),
    .ch_idx(ch_sel),
    .ch_reg(ch_reg),
    .hi    (hi)
  );

  assign wmask    = lane_mask(hi, bus_wide);
  assign wdata_al = lane_data(hi, bus_wdata);
  assign wr_any   = bus_valid && bus_write;
  assign wr_cfg   = wr_any && (tgt == TGT_CFG);
  assign wr_sts   = wr_any && (tgt == TGT_STS);
  assign wr_cnt   = wr_any && (tgt == TGT_CNT);
  assign ch_wr    = wr_any && (tgt == TGT_CH);
  assign ch_wdata = wdata_al & wmask;
  assign ch_wmask = wmask;
  assign sts_clr  = wr_sts ? NCH'(wdata_al & wmask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (wr_cfg)
      cfg_q <= 2'(merge({62'h0, cfg_q}, wdata_al, wmask & CFG_WR));
  end

  assign glb_enable   = cfg_q[0];
  assign legacy_route = cfg_q[1];

  evt_counter #(.W(64)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (glb_enable),
    .tick (tick_en),
    .wr   (wr_cnt),
    .wmask(wmask),
    .wdata(wdata_al),
    .cnt  (cnt)
  );

  evt_status #(.NCH(NCH)) u_sts (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (sts_set),
    .clr  (sts_clr),
    .sts  (sts)
  );

  always_comb begin
    unique case (tgt)
      TGT_CAP: full_rd = CAP;
      TGT_CFG: full_rd = {62'h0, cfg_q};
      TGT_STS: full_rd = 64'(sts);
      TGT_CNT: full_rd = cnt;
      TGT_CH:  full_rd = ch_rdata;
      default: full_rd = '0;
    endcase
  end

  assign bus_rdata = (bus_valid && !bus_write) ? (hi ? (full_rd >> 32) : full_rd) : '0;

  // R4: configuration only changes through a configuration write
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q));

  // R10: the channel strobe never reaches an absent channel
  p_ch_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr |-> (32'(ch_sel) < NCH) && (ch_reg != 2'b11));

  // R2: an upper-half read leaves the top of the bus clear
  p_hi_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && hi) |-> bus_rdata[63:32] == 32'h0);
endmodule

// File: tb/sim_evt_timer_regs.sv
module sim_evt_timer_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;
  localparam logic [63:0] CAPV = 64'h0098_9680_A5C3_A401;
  localparam logic [63:0] CHV  = 64'h0123_4567_89AB_CDEF;
  localparam int NV = 15;

  // {write, wide, byte address[9:0], data, expected}
  localparam logic [139:0] TBL [0:NV-1] = '{
    {1'b0, 1'b1, 10'h000, 64'h0, CAPV},
    {1'b0, 1'b0, 10'h004, 64'h0, 64'h0000_0000_0098_9680},
    {1'b1, 1'b1, 10'h000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {1'b0, 1'b1, 10'h000, 64'h0, CAPV},
    {1'b1, 1'b1, 10'h010, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0},
    {1'b0, 1'b1, 10'h010, 64'h0, 64'h0},
    {1'b1, 1'b0, 10'h0F0, 64'hFFFF_FFFF_1234_5678, 64'h0},
    {1'b1, 1'b0, 10'h0F4, 64'h0000_0000_0000_0009, 64'h0},
    {1'b0, 1'b1, 10'h0F0, 64'h0, 64'h0000_0009_1234_5678},
    {1'b0, 1'b0, 10'h0F4, 64'h0, 64'h0000_0000_0000_0009},
    {1'b0, 1'b1, 10'h018, 64'h0, 64'h0},
    {1'b0, 1'b1, 10'h100, 64'h0, CHV},
    {1'b0, 1'b0, 10'h184, 64'h0, 64'h0000_0000_0123_4567},
    {1'b0, 1'b1, 10'h1A0, 64'h0, 64'h0},
    {1'b0, 1'b1, 10'h118, 64'h0, 64'h0}
  };
  localparam string TAG [0:NV-1] = '{
    "R3 cap", "R2 cap hi", "", "R3 cap ro", "", "R4 cfg mask", "", "",
    "R7 preload", "R2 cnt hi", "R1 undefined", "R9 ch read", "R9 ch hi",
    "R10 ch range", "R10 reg3"
  };

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_wide = 0;
  logic [9:0] baddr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic tick_en = 0;
  logic [NCH-1:0] sts_set = '0;
  logic [4:0] ch_sel;
  logic [1:0] ch_reg;
  logic ch_wr, glb_enable, legacy_route;
  logic [63:0] ch_wdata, ch_wmask;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer_regs #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(baddr[9:2]), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_en(tick_en), .sts_set(sts_set),
    .ch_rdata(CHV), .ch_sel(ch_sel), .ch_reg(ch_reg), .ch_wr(ch_wr),
    .ch_wdata(ch_wdata), .ch_wmask(ch_wmask), .glb_enable(glb_enable),
    .legacy_route(legacy_route)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic wide, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_wide = wide; baddr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic wide, output logic [63:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_wide = wide; baddr = a;
    #1 d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(posedge clk);
    #1 tick_en = 0;
  endtask

  logic [63:0] v;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11 reset state
    rd(10'h010, 1, v); check("R11 cfg reset", v, 64'h0);
    rd(10'h0F0, 1, v); check("R11 cnt reset", v, 64'h0);
    rd(10'h020, 1, v); check("R11 sts reset", v, 64'h0);
    check("R11 enable reset", {63'h0, glb_enable}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][139]) wr(TBL[i][137:128], TBL[i][138], TBL[i][127:64]);
      else begin
        rd(TBL[i][137:128], TBL[i][138], v);
        check(TAG[i], v, TBL[i][63:0]);
      end
    end

    // R6 / R7 / R8 counting
    wr(10'h0F0, 1, 64'd100);
    wr(10'h010, 1, 64'h1);
    check("R4 enable out", {63'h0, glb_enable}, 64'h1);
    ticks(10);
    rd(10'h0F0, 1, v); check("R6 count", v, 64'd110);
    wr(10'h010, 1, 64'h0);
    ticks(5);
    rd(10'h0F0, 1, v); check("R7 frozen", v, 64'd110);
    wr(10'h010, 1, 64'h1);
    wr(10'h0F0, 1, 64'h0);
    rd(10'h0F0, 1, v); check("R8 write ignored", v, 64'd110);
    ticks(3);
    rd(10'h0F0, 1, v); check("R7 resume", v, 64'd113);
    wr(10'h010, 0, 64'h2);
    check("R4 legacy out", {62'h0, legacy_route, glb_enable}, 64'h2);
    wr(10'h010, 1, 64'h0);

    // R5 status
    @(negedge clk); sts_set = 5'b10110;
    @(posedge clk); #1 sts_set = '0;
    rd(10'h020, 1, v); check("R5 set", v, 64'h16);
    wr(10'h020, 1, 64'h12);
    rd(10'h020, 1, v); check("R5 w1c", v, 64'h04);
    wr(10'h020, 1, 64'h0);
    rd(10'h020, 1, v); check("R5 zero write", v, 64'h04);
    wr(10'h024, 0, 64'hFFFF_FFFF);
    rd(10'h020, 1, v); check("R2 sts hi write", v, 64'h04);
    @(negedge clk);
    sts_set = 5'b00100; bus_valid = 1; bus_write = 1; bus_wide = 1;
    baddr = 10'h020; bus_wdata = 64'h4;
    @(posedge clk); #1 sts_set = '0; bus_valid = 0; bus_write = 0;
    rd(10'h020, 1, v); check("R5 set wins", v, 64'h04);

    // R9 channel write forwarding
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_wide = 0; baddr = 10'h12C; bus_wdata = 64'hAABB_CCDD;
    #1;
    check("R9 ch_wr", {63'h0, ch_wr}, 64'h1);
    check("R9 ch_sel/reg", {57'h0, ch_sel, ch_reg}, {57'h0, 5'd1, 2'd1});
    check("R9 ch_wdata", ch_wdata, 64'hAABB_CCDD_0000_0000);
    check("R9 ch_wmask", ch_wmask, 64'hFFFF_FFFF_0000_0000);
    baddr = 10'h1A8; #1;
    check("R10 ch5 no strobe", {63'h0, ch_wr}, 64'h0);
    baddr = 10'h118; #1;
    check("R10 reg3 no strobe", {63'h0, ch_wr}, 64'h0);
    @(posedge clk); #1 bus_valid = 0; bus_write = 0;

    // R11 reset mid run
    wr(10'h010, 1, 64'h3);
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    rd(10'h010, 1, v); check("R11 cfg after reset", v, 64'h0);
    rd(10'h0F0, 1, v); check("R11 cnt after reset", v, 64'h0);
    rd(10'h020, 1, v); check("R11 sts after reset", v, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule